// File: doc/BRIEF.md
# Single-Bit Fourth-Order Fraction Modulator

This block turns a signed fraction word into a one-bit stream, one bit per comparison period. Over a long run, the number of ones minus half the number of cycles, divided by the cycle count, equals the input word divided by a fixed modulus of 62976. A divider control path adds the bit to an integer modulus step. The bit is then low-pass filtered by the loop around it, and the output frequency lands between two integer divide ratios.

Inside are four accumulators in a single loop. Each later stage takes an arithmetic right shift of the stage before it. The registered output bit selects a constant feedback value that every stage subtracts (bit 1) or adds (bit 0). The first stage's feedback magnitude is half the modulus, 31488. A range guard watches the input word. When an enabled input falls outside the permitted open range, all accumulators and the output bit are cleared at once, and a flag is raised for the next cycle. The accumulators saturate instead of wrapping.

Top module: `frac_dsm4`

## Requirements
- R1: While the reset input is low and in the first cycle after it rises, the output bit and the range flag both read 0.
- R2: For any input word k with |k| <= 20000, once 2048 enabled cycles have passed, a window of 65536 enabled cycles gives (ones - cycles/2)/cycles within 1e-3 of k/62976.
- R3: With k = 0, a window of 16384 enabled cycles after the 2048-cycle settle holds a ones fraction within 3e-3 of one half.
- R4: An enabled cycle whose k satisfies k >= 31488 or k <= -31488 raises the range flag in the following cycle, for that one cycle per such sample. An enabled cycle with -31488 < k < 31488 never raises it.
- R5: The range trip clears every accumulator and the output bit. The bit reads 0 while the flag is high. The bit stream that follows, for a given k, is identical to the stream that follows a reset with the same k.
- R6: Bit value 1 makes each stage subtract its feedback magnitude and bit value 0 makes it add. So the first enabled in-range cycle after reset or after a range trip produces a 1.
- R7: While the enable is low, the output bit holds, the range flag stays 0 even for an out-of-range k, and no state advances. The stream resumes exactly where it paused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Comparison-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en | input | 1 | Advances the modulator by one step when high |
| k | input | 17 | Signed fraction word, two's complement |
| dsm_bit | output | 1 | Registered one-bit modulator output |
| range_trip | output | 1 | High for one cycle after an enabled out-of-range input sample |

## Verification
On every cycle, the assertions check the following. A raised range flag coincides with a zero output bit and zeroed accumulators. The first in-range step out of a cleared state yields a 1. An idle cycle changes neither the bit nor the flag. The bench scenarios are needed for the long-run mean of the bit stream against k/62976 and for the balanced stream at k = 0. They also show the range boundaries at ±31487 and ±31488, that the stream after a trip matches the stream after a reset, and that a paused stream continues bit for bit.

// File: rtl/fdsm_pkg.sv
package fdsm_pkg;

  localparam int unsigned FDSM_STAGES = 4;

  typedef enum logic {
    FB_ADD = 1'b0,
    FB_SUB = 1'b1
  } fb_dir_e;

  function automatic fb_dir_e fb_dir_of(input logic out_bit);
    return out_bit ? FB_SUB : FB_ADD;
  endfunction

endpackage

// File: rtl/dsm_acc_stage.sv
module dsm_acc_stage
  import fdsm_pkg::*;
#(
  parameter int ACC_W  = 24,
  parameter int IN_W   = 17,
  parameter int SHIFT  = 0,
  parameter int FB_MAG = 31488
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    clr,
  input  logic                    fb_bit,
  input  logic signed [IN_W-1:0]  din,
  output logic signed [ACC_W-1:0] acc_o,
  output logic signed [ACC_W-1:0] acc_nxt_o
);

  localparam int SW = ACC_W + 2;
  localparam logic signed [SW-1:0] FB_POS  = SW'(FB_MAG);
  localparam logic signed [SW-1:0] SAT_HI  = SW'((64'sd1 <<< (ACC_W-1)) - 1);
  localparam logic signed [SW-1:0] SAT_LO  = -SAT_HI;

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_d;
  logic signed [SW-1:0]    din_x;
  logic signed [SW-1:0]    din_s;
  logic signed [SW-1:0]    acc_x;
  logic signed [SW-1:0]    fb_val;
  logic signed [SW-1:0]    sum;
  logic signed [ACC_W-1:0] sat_val;

  always_comb begin
    din_x  = {{(SW-IN_W){din[IN_W-1]}}, din};
    din_s  = din_x >>> SHIFT;
    acc_x  = {{(SW-ACC_W){acc_q[ACC_W-1]}}, acc_q};
    fb_val = (fb_dir_of(fb_bit) == FB_SUB) ? -FB_POS : FB_POS;
    sum    = acc_x + din_s + fb_val;
    if (sum > SAT_HI) begin
      sat_val = SAT_HI[ACC_W-1:0];
    end else if (sum < SAT_LO) begin
      sat_val = SAT_LO[ACC_W-1:0];
    end else begin
      sat_val = sum[ACC_W-1:0];
    end
  end

  always_comb begin
    if (clr) begin
      acc_d = '0;
    end else if (en) begin
      acc_d = sat_val;
    end else begin
      acc_d = acc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  assign acc_o     = acc_q;
  assign acc_nxt_o = acc_d;

endmodule

// File: rtl/dsm_range_guard.sv
module dsm_range_guard #(
  parameter int K_W   = 17,
  parameter int LIMIT = 31488
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic signed [K_W-1:0] k,
  output logic                  clr,
  output logic                  trip_o
);

  localparam logic signed [K_W:0] LIM_P = (K_W+1)'(LIMIT);
  localparam logic signed [K_W:0] LIM_N = -LIM_P;

  logic signed [K_W:0] k_x;
  logic                outside;
  logic                trip_q;
  logic                trip_d;

  always_comb begin
    k_x     = {k[K_W-1], k};
    outside = (k_x >= LIM_P) || (k_x <= LIM_N);
    clr     = en && outside;
    trip_d  = clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_q <= 1'b0;
    end else begin
      trip_q <= trip_d;
    end
  end

  assign trip_o = trip_q;

endmodule

// File: rtl/dsm_bit_quant.sv
module dsm_bit_quant (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  input  logic last_msb_nxt,
  output logic bit_o
);

  logic bit_q;
  logic bit_d;

  always_comb begin
    if (clr) begin
      bit_d = 1'b0;
    end else if (en) begin
      bit_d = !last_msb_nxt;
    end else begin
      bit_d = bit_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
    end else begin
      bit_q <= bit_d;
    end
  end

  assign bit_o = bit_q;

endmodule

// File: rtl/frac_dsm4.sv
module frac_dsm4
  import fdsm_pkg::*;
#(
  parameter int K_W      = 17,
  parameter int ACC_W    = 24,
  parameter int MODULUS  = 62976,
  parameter int FB2_MAG  = 31488,
  parameter int FB3_MAG  = 31488,
  parameter int FB4_MAG  = 31488,
  parameter int A2_SHIFT = 8,
  parameter int A3_SHIFT = 6,
  parameter int A4_SHIFT = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic signed [K_W-1:0] k,
  output logic                  dsm_bit,
  output logic                  range_trip
);

  localparam int HALF_MOD = MODULUS / 2;
  localparam int NST      = FDSM_STAGES;

  function automatic int stage_shift(input int j);
    case (j)
      1:       return A2_SHIFT;
      2:       return A3_SHIFT;
      3:       return A4_SHIFT;
      default: return 0;
    endcase
  endfunction

  function automatic int stage_fb(input int j);
    case (j)
      1:       return FB2_MAG;
      2:       return FB3_MAG;
      3:       return FB4_MAG;
      default: return HALF_MOD;
    endcase
  endfunction

  logic                    clr;
  logic signed [ACC_W-1:0] acc_q   [NST];
  logic signed [ACC_W-1:0] acc_nxt [NST];

  dsm_range_guard #(
    .K_W   (K_W),
    .LIMIT (HALF_MOD)
  ) u_guard (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .k      (k),
    .clr    (clr),
    .trip_o (range_trip)
  );

  for (genvar j = 0; j < NST; j++) begin : g_stage
    if (j == 0) begin : g_head
      dsm_acc_stage #(
        .ACC_W  (ACC_W),
        .IN_W   (K_W),
        .SHIFT  (stage_shift(j)),
        .FB_MAG (stage_fb(j))
      ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .clr       (clr),
        .fb_bit    (dsm_bit),
        .din       (k),
        .acc_o     (acc_q[j]),
        .acc_nxt_o (acc_nxt[j])
      );
    end else begin : g_tail
      dsm_acc_stage #(
        .ACC_W  (ACC_W),
        .IN_W   (ACC_W),
        .SHIFT  (stage_shift(j)),
        .FB_MAG (stage_fb(j))
      ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .clr       (clr),
        .fb_bit    (dsm_bit),
        .din       (acc_q[j-1]),
        .acc_o     (acc_q[j]),
        .acc_nxt_o (acc_nxt[j])
      );
    end
  end

  dsm_bit_quant u_quant (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .clr          (clr),
    .last_msb_nxt (acc_nxt[NST-1][ACC_W-1]),
    .bit_o        (dsm_bit)
  );

  AST_TRIP_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    range_trip |-> !dsm_bit) else $error("trip with bit set"); // R5

  AST_TRIP_STATE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    range_trip |-> (acc_q[0] == '0 && acc_q[NST-1] == '0)) else $error("trip with live state"); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> ($stable(dsm_bit) && !range_trip)) else $error("idle cycle moved state"); // R7

  AST_FIRST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(range_trip) && $past(en) && !range_trip) |-> dsm_bit) else $error("first step after clear not 1"); // R6

endmodule

// File: tb/sim_frac_dsm4.sv
module sim_frac_dsm4;

  logic               clk;
  logic               rst_n;
  logic               en;
  logic signed [16:0] k;
  logic               dsm_bit;
  logic               range_trip;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  typedef struct {
    string tag;
    int    n;
    real   expect_v;
    real   tol;
  } item_t;

  item_t sb_q[$];

  logic ref_a [0:119];
  logic ref_b [0:119];

  frac_dsm4 u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .k          (k),
    .dsm_bit    (dsm_bit),
    .range_trip (range_trip)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    en    = 1'b0;
    k     = '0;
    repeat (3) @(negedge clk);
    chk(dsm_bit == 1'b0, "R1", "bit in reset", int'(dsm_bit), 0);
    chk(range_trip == 1'b0, "R1", "flag in reset", int'(range_trip), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dsm_bit == 1'b0 && range_trip == 1'b0, "R1", "outputs after release",
        int'({dsm_bit, range_trip}), 0);
  endtask

  task automatic mean_run(input int kv, input int n, input real tol, input string tag);
    item_t it;
    k  = 17'(kv);
    en = 1'b1;
    repeat (2048) @(negedge clk);
    it.tag      = tag;
    it.n        = n;
    it.expect_v = real'(kv) / 62976.0;
    it.tol      = tol;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  initial begin : monitor
    forever begin
      item_t it;
      int    ones;
      real   got;
      wait (sb_q.size() > 0);
      it   = sb_q[0];
      ones = 0;
      repeat (it.n) begin
        @(negedge clk);
        ones += int'(dsm_bit);
      end
      got = (real'(ones) - real'(it.n) / 2.0) / real'(it.n);
      checks++;
      if (got - it.expect_v > it.tol || it.expect_v - got > it.tol) begin
        failures++;
        $display("FAIL %s mean actual=%f expected=%f", it.tag, got, it.expect_v);
      end
      void'(sb_q.pop_front());
    end
  end

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 1'b0;
    en    = 1'b0;
    k     = '0;
    do_reset();

    // R6: zero state, bit 0 adds feedback, so the first step yields 1
    k  = 17'sd0;
    en = 1'b1;
    @(negedge clk);
    chk(dsm_bit == 1'b1, "R6", "first step after reset", int'(dsm_bit), 1);

    // R3: balanced stream for zero input
    do_reset();
    mean_run(0, 16384, 3.0e-3, "R3");

    // R2: long windows, positive and negative words
    do_reset();
    mean_run(12000, 65536, 1.0e-3, "R2");
    do_reset();
    mean_run(-17000, 65536, 1.0e-3, "R2");
    do_reset();
    mean_run(3000, 16384, 3.0e-3, "R2");

    // R4: range boundaries
    do_reset();
    en = 1'b1;
    k  = 17'sd31487;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk(range_trip == 1'b0, "R4", "+31487 accepted", int'(range_trip), 0);
    end
    k = -17'sd31487;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk(range_trip == 1'b0, "R4", "-31487 accepted", int'(range_trip), 0);
    end
    k = -17'sd31488;
    @(negedge clk);
    chk(range_trip == 1'b1, "R4", "-31488 trips", int'(range_trip), 1);
    k = 17'sd40000;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(range_trip == 1'b1, "R4", "held out-of-range trips", int'(range_trip), 1);
    end
    k = 17'sd100;
    @(negedge clk);
    chk(range_trip == 1'b0, "R4", "flag drops after one cycle", int'(range_trip), 0);

    // R5: stream after a trip equals the stream after reset
    do_reset();
    k  = 17'sd5000;
    en = 1'b1;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      ref_a[i] = dsm_bit;
    end
    k = 17'sd9000;
    repeat (300) @(negedge clk);
    k = 17'sd31488;
    @(negedge clk);
    chk(range_trip == 1'b1, "R4", "+31488 trips", int'(range_trip), 1);
    chk(dsm_bit == 1'b0, "R5", "bit cleared on trip", int'(dsm_bit), 0);
    k = 17'sd5000;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      ref_b[i] = dsm_bit;
    end
    for (int i = 0; i < 64; i++) begin
      chk(ref_a[i] == ref_b[i], "R5", $sformatf("post-trip bit %0d", i),
          int'(ref_b[i]), int'(ref_a[i]));
    end

    // R7: pause with enable low, out-of-range word ignored
    do_reset();
    k  = 17'sd7000;
    en = 1'b1;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      ref_a[i] = dsm_bit;
    end
    do_reset();
    k  = 17'sd7000;
    en = 1'b1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      ref_b[i] = dsm_bit;
    end
    en = 1'b0;
    k  = 17'sd40000;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(dsm_bit == ref_b[49], "R7", "bit held while idle", int'(dsm_bit), int'(ref_b[49]));
      chk(range_trip == 1'b0, "R7", "no flag while idle", int'(range_trip), 0);
    end
    k  = 17'sd7000;
    en = 1'b1;
    for (int i = 50; i < 120; i++) begin
      @(negedge clk);
      ref_b[i] = dsm_bit;
    end
    for (int i = 0; i < 120; i++) begin
      chk(ref_a[i] == ref_b[i], "R7", $sformatf("resumed bit %0d", i),
          int'(ref_b[i]), int'(ref_a[i]));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule